// File: doc/BRIEF.md
# Polled Serial Byte Receiver

This block takes in an asynchronous serial line carrying 8-bit characters (one start bit, eight data bits, one stop bit, no parity) at a fixed rate. The rate is set by a parameter that gives the length of one bit in clock cycles. Each good character goes into a four-entry first-in first-out store. The default bit length is 3072 cycles, which suits a 96 MHz clock at 31250 baud.

A processor reaches the block through one bus-mapped read register. Each cycle in which the read select is high removes the oldest byte. One cycle later the block presents a 32-bit word. That word holds the byte, a flag that says whether the byte is real, and a sticky flag that says bytes were lost. Software can therefore poll a single address and needs no separate status read.

Top module: `serial_rx_port`

## Requirements
- R1: The line input passes through one register that resets to high (idle). After reset `rd_data` is all zeros, and an idle line produces no bytes.
- R2: A frame begins on a falling edge of the line. Data bits are taken least significant first at the bit centres, with the bit length set by `CLKS_PER_BIT` cycles. Each completed frame delivers its byte exactly once.
- R3: The store holds `FIFO_DEPTH` bytes (default four) and returns them in arrival order.
- R4: In the read word, bits 7:0 hold the byte, bit 30 is 1 when a byte was removed, and bit 31 is 1 when bytes were lost. Bits 29:8 are always 0.
- R5: A read select in cycle t updates `rd_data` after the clock edge that ends cycle t. The word then holds until the next read.
- R6: A byte that arrives while the store is full, with no read in that cycle, is discarded and the lost flag is set. The next read reports bit 31 as 1 and clears the flag.
- R7: A read of an empty store returns bit 30 as 0 and bits 7:0 as 0, and it leaves the store unchanged. Bytes that arrive later read out correctly.
- R8: A frame whose stop bit is low is dropped and nothing is stored.
- R9: A low pulse shorter than half a bit, checked again at the start-bit centre, does not start a frame.
- R10: An arrival and a read in the same cycle, on a store that is neither empty nor full, leave the occupancy unchanged and lose no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Raw asynchronous serial line, idle high |
| rd_sel | input | 1 | Bus read select; each high cycle removes one entry |
| rd_data | output | 32 | Formatted read word |

## Verification
Every cycle, the assertions check the following:
- the zero field of the read word;
- that the word holds when no read is made;
- that the store's arrival strobe lasts one cycle;
- that occupancy stays put on a simultaneous arrival and removal;
- that a read of an empty store freezes the read pointer;
- that a discarded arrival leaves the store full and untouched;
- that the lost flag stays set until a read.

Only the bench scenarios can show the rest:
- that every one of the 256 byte values comes back bit for bit;
- that order is kept across a full store;
- which read reports the loss;
- that bad-stop frames and short start glitches produce nothing.

A sweep of read timing across the arrival cycle shows that the coincident case loses no byte.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int PAD_W   = WORD_W - BYTE_W - 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } rx_phase_t;

    typedef struct packed {
        logic              lost;
        logic              valid;
        logic [PAD_W-1:0]  pad;
        logic [BYTE_W-1:0] data;
    } rd_word_t;

    function automatic rd_word_t make_word(input logic lost, input logic valid,
                                           input logic [BYTE_W-1:0] data);
        rd_word_t w;
        w.lost  = lost;
        w.valid = valid;
        w.pad   = '0;
        w.data  = valid ? data : '0;
        return w;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_raw,
    output logic line_q
);
    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_raw;
    end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 3072
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int CNT_W  = $clog2(CLKS_PER_BIT);
    localparam int IDX_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(BYTE_W - 1);

    rx_phase_t         phase;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shift;
    logic              line_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shift    <= '0;
            line_d   <= 1'b1;
            byte_stb <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_stb <= 1'b0;
            line_d   <= line;
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (line_d && !line) phase <= PH_START;
                end
                PH_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        idx   <= '0;
                        phase <= line ? PH_IDLE : PH_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt == FULL_LAST) begin
                        cnt   <= '0;
                        shift <= {line, shift[BYTE_W-1:1]};
                        if (idx == IDX_LAST) phase <= PH_STOP;
                        else                 idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (cnt == FULL_LAST) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                        if (line) begin
                            byte_stb <= 1'b1;
                            byte_out <= shift;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a completed frame is announced for exactly one cycle
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);

    // R2: a strobe only follows the stop phase
    assert_strobe_after_stop_R2: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> phase == PH_IDLE);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] head,
    output logic              empty,
    output logic              dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              full, do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CNT_FULL);
    assign do_pop  = pop_req && !empty;
    assign do_push = push && (!full || do_pop);
    assign dropped = push && full && !do_pop;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                     mem[e] <= '0;
            else if (do_push && wr_ptr == AW'(e))        mem[e] <= din;
        end
    end

    // R10: simultaneous arrival and removal keep occupancy
    assert_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop_req && !empty && !full) |=> $stable(count));

    // R7: reading an empty store does not move the read pointer
    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> $stable(rd_ptr));

    // R6: a discarded arrival leaves the store full and untouched
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop_req) |=> (count == CNT_FULL) && $stable(wr_ptr));

    // R3: occupancy never exceeds the depth
    assert_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
    import serial_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 3072,
    parameter int FIFO_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_in,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data
);
    logic              line_s;
    logic              stb;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] head;
    logic              empty, dropped;
    logic              lost_flag;
    rd_word_t          word_q;

    rx_line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw (serial_in),
        .line_q   (line_s)
    );

    rx_framer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .line     (line_s),
        .byte_stb (stb),
        .byte_out (rx_byte)
    );

    rx_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (stb),
        .din     (rx_byte),
        .pop_req (rd_sel),
        .head    (head),
        .empty   (empty),
        .dropped (dropped)
    );

    always_ff @(posedge clk) begin
        if (rst)          lost_flag <= 1'b0;
        else if (dropped) lost_flag <= 1'b1;
        else if (rd_sel)  lost_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (rd_sel) word_q <= make_word(lost_flag, !empty, head);
    end

    assign rd_data = word_q;

    // R4: unused field of the read word stays zero
    assert_zero_field_R4: assert property (@(posedge clk) disable iff (rst)
        rd_data[29:8] == '0);

    // R5: the word only changes after a read
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_sel |=> $stable(rd_data));

    // R6: the lost flag persists until a read
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (lost_flag && !rd_sel) |=> lost_flag);
endmodule

// File: tb/serial_rx_port_test.sv
module serial_rx_port_test;
    localparam int BIT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line = 1'b1;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] w;
    logic [31:0] w0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_rx_port #(.CLKS_PER_BIT(BIT), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .serial_in(line), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [31:0] expw(input logic lost, input logic valid,
                                         input logic [7:0] b);
        return {lost, valid, 22'b0, valid ? b : 8'h00};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v);
        @(negedge clk) line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            line = b[i];
            repeat (BIT) @(negedge clk);
        end
        line = stop_v;
        repeat (BIT) @(negedge clk);
        line = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(output logic [31:0] r);
        @(negedge clk) rd_sel = 1'b1;
        @(negedge clk) rd_sel = 1'b0;
        r = rd_data;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check("R1 reset word", rd_data, 32'h0);
        repeat (3 * BIT) @(negedge clk);
        do_read(w);
        check("R1 idle line gives nothing", w, 32'h0);
        do_read(w);
        check("R7 empty read", w, expw(0, 0, 0));

        // R2 / R4: every byte value
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1);
            do_read(w);
            check("R2 byte sweep", w, expw(0, 1, 8'(b)));
        end

        // R5 hold after read
        send_frame(8'hA5, 1'b1);
        do_read(w);
        repeat (10) @(negedge clk);
        check("R5 word held", rd_data, expw(0, 1, 8'hA5));
        do_read(w);
        check("R7 empty after drain", w, expw(0, 0, 0));

        // R7: empty reads do not disturb pointers
        do_read(w);
        do_read(w);
        send_frame(8'h81, 1'b1);
        send_frame(8'h42, 1'b1);
        do_read(w);
        check("R7 after empty reads first", w, expw(0, 1, 8'h81));
        do_read(w);
        check("R7 after empty reads second", w, expw(0, 1, 8'h42));

        // R3: fill and drain in order
        for (int i = 0; i < 4; i++) send_frame(8'(8'hC0 + i), 1'b1);
        for (int i = 0; i < 4; i++) begin
            do_read(w);
            check("R3 order", w, expw(0, 1, 8'(8'hC0 + i)));
        end
        do_read(w);
        check("R3 empty after four", w, expw(0, 0, 0));

        // R6: overflow
        for (int i = 0; i < 6; i++) send_frame(8'(8'h10 + i), 1'b1);
        do_read(w);
        check("R6 lost reported", w, expw(1, 1, 8'h10));
        for (int i = 1; i < 4; i++) begin
            do_read(w);
            check("R6 flag cleared, kept bytes", w, expw(0, 1, 8'(8'h10 + i)));
        end
        do_read(w);
        check("R6 extra bytes discarded", w, expw(0, 0, 0));

        // R8: bad stop bit
        send_frame(8'h5A, 1'b0);
        send_frame(8'h3C, 1'b1);
        do_read(w);
        check("R8 bad frame dropped", w, expw(0, 1, 8'h3C));
        do_read(w);
        check("R8 nothing else stored", w, expw(0, 0, 0));

        // R9: short start glitch
        @(negedge clk) line = 1'b0;
        repeat (4) @(negedge clk);
        line = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        do_read(w);
        check("R9 glitch ignored", w, expw(0, 0, 0));
        send_frame(8'h99, 1'b1);
        do_read(w);
        check("R9 next frame fine", w, expw(0, 1, 8'h99));

        // R10: sweep read timing across the arrival cycle
        for (int d = 140; d < 176; d++) begin
            send_frame(8'h21, 1'b1);
            send_frame(8'h22, 1'b1);
            fork
                send_frame(8'h23, 1'b1);
                begin
                    repeat (d) @(negedge clk);
                    do_read(w0);
                end
            join
            check("R10 read during arrival", w0, expw(0, 1, 8'h21));
            do_read(w);
            check("R10 second", w, expw(0, 1, 8'h22));
            do_read(w);
            check("R10 third", w, expw(0, 1, 8'h23));
            do_read(w);
            check("R10 drained", w, expw(0, 0, 0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule